// File: doc/BRIEF.md
# Palette Lookup and Pixel Expansion Unit

This block sits between a frame fetch engine and the display output. It takes one fetched pixel word per valid cycle and produces one 24-bit RGB pixel (red in the high byte, blue in the low byte) exactly one clock later. The incoming word is decoded according to a display mode. An 8-bit value can be an index into a 256-entry color table. A 16-bit value can be packed color, either 5-6-5 or 5-5-5. A 32-bit word can carry direct 24-bit color, which can bypass the table or be passed through it one component at a time for per-channel correction.

Software fills the color table through two registers. A write to the address register selects an entry. Each write to the data register then stores a 24-bit color at that entry and moves the address forward by one, so a full table can be loaded after a single address write. Reading the data register returns the entry at the current address. Reading the address register returns the address itself.

Top module: `pxf_unit`

## Requirements
- R1: After reset, `outValid` is 0, `outPixel` is 0, and the address register reads as 0.
- R2: A write with `regSel`=0 loads the address from `regWrData[7:0]`. Reading with `regSel`=0 returns the address in bits 7:0, with zeros above.
- R3: A write with `regSel`=1 stores `regWrData[23:0]` at the current address, and bits 31:24 are ignored. Reading with `regSel`=1 returns the entry at the current address in bits 23:0, with zeros in bits 31:24.
- R4: Each data write advances the address by one, wrapping from 255 to 0. Reads and address-register writes do not advance it.
- R5: In mode 2'b00 (indexed), `outPixel` is the table entry selected by `inPixel[7:0]`.
- R6: In mode 2'b01 with `fmt565`=1, `inPixel[15:11]`, `[10:5]` and `[4:0]` are red, green and blue. Each is widened to 8 bits by copying its top bits into the new low bits.
- R7: In mode 2'b01 with `fmt565`=0, `inPixel[14:10]`, `[9:5]` and `[4:0]` are red, green and blue, each widened the same way. Bit 15 is ignored.
- R8: In mode 2'b10 with `palBypass`=1, `outPixel` equals `inPixel[23:0]`, and bits 31:24 are ignored.
- R9: In mode 2'b10 with `palBypass`=0, each output component is taken from the same byte lane of the table entry indexed by that input component.
- R10: Mode 2'b11 is reserved and produces a black (all-zero) pixel.
- R11: `outValid` follows `inValid` one cycle later. `outPixel` changes only in a cycle after `inValid` was high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the address register, 1 selects the data register |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for the register picked by `regSel` |
| inValid | input | 1 | Input pixel qualifier |
| inPixel | input | 32 | Fetched pixel word |
| mode | input | 2 | Display mode: 00 indexed, 01 16-bit, 10 direct, 11 reserved |
| fmt565 | input | 1 | In 16-bit mode, 1 selects 5-6-5 and 0 selects 5-5-5 |
| palBypass | input | 1 | In direct mode, 1 skips the table |
| outValid | output | 1 | Output pixel qualifier |
| outPixel | output | 24 | RGB pixel, red [23:16], green [15:8], blue [7:0] |

## Verification
The bench loads all 256 entries with a single address write and then confirms that the address has wrapped back to 0. A design that fails to increment, or that saturates at 255, leaves the address wrong and places later entries in the wrong slots. Each entry has distinct byte lanes and junk in bits 31:24. A design that stores or returns the top byte, or that swaps lanes during per-component correction, gives wrong colors. The 16-bit patterns use component values whose top bits differ from their low bits, so a widening that pads with zeros or copies the wrong bits shows up at once. Idle cycles between pixels check that the output holds and that the valid signal is not stretched.

// File: rtl/pxf_pkg.sv
`timescale 1ns/1ps
package pxf_pkg;
  localparam int IDX_W  = 8;
  localparam int COMP_W = 8;
  localparam int NCOMP  = 3;
  localparam int PIX_W  = NCOMP * COMP_W;
  localparam int BUS_W  = 32;
  localparam int DEPTH  = 1 << IDX_W;

  typedef enum logic [1:0] {
    MODE_IDX8   = 2'b00,
    MODE_RGB16  = 2'b01,
    MODE_DIRECT = 2'b10,
    MODE_RSVD   = 2'b11
  } dispMode_t;

  typedef struct packed {
    logic             palWe;
    logic [IDX_W-1:0] palAddr;
    logic [PIX_W-1:0] palData;
  } palStrobe_t;

  function automatic logic [COMP_W-1:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [COMP_W-1:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction
endpackage

// File: rtl/pxf_ctrl.sv
`timescale 1ns/1ps
module pxf_ctrl
  import pxf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [BUS_W-1:0] regWrData,
  output palStrobe_t       strobe,
  output logic [IDX_W-1:0] curAddr
);
  logic [IDX_W-1:0] addrQ;
  logic             addrWr;
  logic             dataWr;

  assign addrWr = regWrEn && !regSel;
  assign dataWr = regWrEn && regSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (addrWr) begin
      addrQ <= regWrData[IDX_W-1:0];
    end else if (dataWr) begin
      addrQ <= addrQ + 1'b1;
    end
  end

  always_comb begin
    strobe.palWe   = dataWr;
    strobe.palAddr = addrQ;
    strobe.palData = regWrData[PIX_W-1:0];
  end

  assign curAddr = addrQ;

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    addrWr |=> curAddr == $past(regWrData[IDX_W-1:0])); // R2
  AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> curAddr == $past(curAddr) + 1'b1); // R4
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(curAddr)); // R4
endmodule

// File: rtl/pxf_datapath.sv
`timescale 1ns/1ps
module pxf_datapath
  import pxf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  palStrobe_t       strobe,
  input  logic [IDX_W-1:0] curAddr,
  output logic [PIX_W-1:0] curEntry,
  input  logic             inValid,
  input  logic [BUS_W-1:0] inPixel,
  input  logic [1:0]       mode,
  input  logic             fmt565,
  input  logic             palBypass,
  output logic             outValid,
  output logic [PIX_W-1:0] outPixel
);
  logic [PIX_W-1:0] palMem [DEPTH];
  logic [PIX_W-1:0] idxEntry;
  logic [PIX_W-1:0] rgb16Pix;
  logic [PIX_W-1:0] corrPix;
  logic [PIX_W-1:0] nextPix;
  dispMode_t        modeD;

  always_ff @(posedge clk) begin
    if (strobe.palWe) palMem[strobe.palAddr] <= strobe.palData;
  end

  assign curEntry = palMem[curAddr];
  assign idxEntry = palMem[inPixel[IDX_W-1:0]];

  always_comb begin
    if (fmt565)
      rgb16Pix = {widen5(inPixel[15:11]), widen6(inPixel[10:5]), widen5(inPixel[4:0])};
    else
      rgb16Pix = {widen5(inPixel[14:10]), widen5(inPixel[9:5]), widen5(inPixel[4:0])};
  end

  for (genvar c = 0; c < NCOMP; c++) begin : g_corr
    logic [PIX_W-1:0] laneEntry;
    assign laneEntry = palMem[inPixel[c*COMP_W +: COMP_W]];
    assign corrPix[c*COMP_W +: COMP_W] = laneEntry[c*COMP_W +: COMP_W];
  end

  assign modeD = dispMode_t'(mode);

  always_comb begin
    unique case (modeD)
      MODE_IDX8:   nextPix = idxEntry;
      MODE_RGB16:  nextPix = rgb16Pix;
      MODE_DIRECT: nextPix = palBypass ? inPixel[PIX_W-1:0] : corrPix;
      default:     nextPix = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPixel <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) outPixel <= nextPix;
    end
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R11
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R11
  AST_PIXEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outPixel)); // R11
  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == MODE_DIRECT && palBypass) |=> outPixel == $past(inPixel[PIX_W-1:0])); // R8
  AST_RSVD_BLACK: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == MODE_RSVD) |=> outPixel == '0); // R10
  AST_ENTRY_STORED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.palWe |=> palMem[$past(strobe.palAddr)] == $past(strobe.palData)); // R3
endmodule

// File: rtl/pxf_unit.sv
`timescale 1ns/1ps
module pxf_unit
  import pxf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regSel,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        inValid,
  input  logic [31:0] inPixel,
  input  logic [1:0]  mode,
  input  logic        fmt565,
  input  logic        palBypass,
  output logic        outValid,
  output logic [23:0] outPixel
);
  palStrobe_t       strobe;
  logic [IDX_W-1:0] curAddr;
  logic [PIX_W-1:0] curEntry;

  pxf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .strobe(strobe), .curAddr(curAddr)
  );

  pxf_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curAddr(curAddr),
    .curEntry(curEntry), .inValid(inValid), .inPixel(inPixel),
    .mode(mode), .fmt565(fmt565), .palBypass(palBypass),
    .outValid(outValid), .outPixel(outPixel)
  );

  assign regRdData = regSel ? {{(BUS_W-PIX_W){1'b0}}, curEntry}
                            : {{(BUS_W-IDX_W){1'b0}}, curAddr};
endmodule

// File: tb/pxf_unit_test.sv
`timescale 1ns/1ps
module pxf_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        inValid = 1'b0;
  logic [31:0] inPixel = '0;
  logic [1:0]  mode = 2'b00;
  logic        fmt565 = 1'b0;
  logic        palBypass = 1'b0;
  logic        outValid;
  logic [23:0] outPixel;

  int checks = 0;
  int errors = 0;
  logic [23:0] model [256];

  always #2.5 clk = ~clk;

  pxf_unit uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic sel, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic sel, output logic [31:0] d);
    @(negedge clk);
    regSel = sel;
    #1 d = regRdData;
  endtask

  function automatic logic [7:0] ex5(input logic [4:0] v);
    return (8'(v) << 3) | (8'(v) >> 2);
  endfunction
  function automatic logic [7:0] ex6(input logic [5:0] v);
    return (8'(v) << 2) | (8'(v) >> 4);
  endfunction

  task automatic sendPixel(input logic [1:0] m, input logic f, input logic b,
                           input logic [31:0] p, output logic [23:0] got);
    @(negedge clk);
    inValid = 1'b1; mode = m; fmt565 = f; palBypass = b; inPixel = p;
    @(negedge clk);
    inValid = 1'b0;
    got = outPixel;
    check("R11 valid after pixel", 32'(outValid), 32'd1);
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 outValid", 32'(outValid), 32'd0);
    check("R1 outPixel", 32'(outPixel), 32'd0);
    regRead(1'b0, d);
    check("R1 address", d, 32'd0);
  endtask

  task automatic testLoad();
    logic [31:0] d;
    regWrite(1'b0, 32'hFFFF_FF00);
    regRead(1'b0, d);
    check("R2 address load ignores upper bits", d, 32'd0);
    for (int i = 0; i < 256; i++) begin
      model[i] = {8'(i) ^ 8'h5A, 8'(i * 3), ~8'(i)};
      regWrite(1'b1, {8'hAB, model[i]});
    end
    regRead(1'b0, d);
    check("R4 wrap to 0 after 256 writes", d, 32'd0);
    regWrite(1'b0, 32'd77);
    regRead(1'b0, d);
    check("R2 address readback", d, 32'd77);
    regRead(1'b1, d);
    check("R3 data readback top byte zero", d, {8'h00, model[77]});
    regRead(1'b0, d);
    check("R4 reads do not advance", d, 32'd77);
    regWrite(1'b0, 32'd255);
    regWrite(1'b1, 32'hCC12_3456);
    model[255] = 24'h123456;
    regRead(1'b0, d);
    check("R4 wrap from 255", d, 32'd0);
    regWrite(1'b0, 32'd255);
    regRead(1'b1, d);
    check("R3 stored low 24 bits", d, 32'h0012_3456);
  endtask

  task automatic testIndexed();
    logic [23:0] got;
    sendPixel(2'b00, 1'b0, 1'b0, 32'hFFFF_FF03, got);
    check("R5 indexed 3", 32'(got), 32'(model[3]));
    sendPixel(2'b00, 1'b1, 1'b1, 32'h0000_00C8, got);
    check("R5 indexed 200", 32'(got), 32'(model[200]));
    sendPixel(2'b00, 1'b0, 1'b0, 32'h0000_00FF, got);
    check("R5 indexed 255", 32'(got), 32'(model[255]));
  endtask

  task automatic testRgb16();
    logic [23:0] got;
    logic [15:0] p;
    p = {5'b10011, 6'b110001, 5'b01101};
    sendPixel(2'b01, 1'b1, 1'b0, {16'hDEAD, p}, got);
    check("R6 565 expand", 32'(got), 32'({ex5(p[15:11]), ex6(p[10:5]), ex5(p[4:0])}));
    p = 16'hFFFF;
    sendPixel(2'b01, 1'b1, 1'b0, {16'h0, p}, got);
    check("R6 565 white", 32'(got), 32'h00FF_FFFF);
    p = {1'b1, 5'b10110, 5'b00111, 5'b11001};
    sendPixel(2'b01, 1'b0, 1'b0, {16'h0, p}, got);
    check("R7 555 expand", 32'(got), 32'({ex5(p[14:10]), ex5(p[9:5]), ex5(p[4:0])}));
  endtask

  task automatic testDirect();
    logic [23:0] got;
    sendPixel(2'b10, 1'b0, 1'b1, 32'h9912_34F0, got);
    check("R8 bypass", 32'(got), 32'h0012_34F0);
    sendPixel(2'b10, 1'b0, 1'b0, 32'h7710_2030, got);
    check("R9 per-component", 32'(got),
          32'({model[8'h10][23:16], model[8'h20][15:8], model[8'h30][7:0]}));
    sendPixel(2'b11, 1'b0, 1'b1, 32'hFFFF_FFFF, got);
    check("R10 reserved black", 32'(got), 32'd0);
  endtask

  task automatic testHold();
    logic [23:0] got;
    sendPixel(2'b10, 1'b0, 1'b1, 32'h00AB_CDEF, got);
    @(negedge clk);
    inPixel = 32'h0011_2233;
    @(negedge clk);
    check("R11 valid drops", 32'(outValid), 32'd0);
    check("R11 pixel holds", 32'(outPixel), 32'h00AB_CDEF);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLoad();
    testIndexed();
    testRgb16();
    testDirect();
    testHold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule